// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block arbitrates six interrupt sources for a small microcontroller core. Each source has an enable bit, and a global enable gates all of them. Two priority bit-vectors, a high one and a low one, place each source on one of four levels. Among the pending and enabled sources the block picks the one on the highest level. Ties on a level go to the source earliest in a fixed polling order. The block presents the winner's vector address to the CPU.

The block keeps one in-service bit for each level. A new request is offered to the CPU only if its level is strictly above every level already in service, so nesting goes at most four deep. When the CPU accepts a request (acknowledge while a request is offered), the winner's level is marked in service. The winner's request flag is also cleared, but only for the source types whose flags the hardware owns. A return strobe retires the highest level in service.

External requests can be edge-latched or follow their pin. Timer 0 and timer 1 overflows arrive as single-cycle set pulses. The serial port and timer 2 present level requests, and their flags stay in those peripherals. All inputs are synchronous to `clk`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and until the first stimulus after release, `irq_valid` is 0, `in_service` is 0000, and every latched flag (edge-mode external, timer 0, timer 1) reads 0 in `irq_flags`.
- R2: A source's level is {`prio_hi[i]`,`prio_lo[i]`}, 3 the highest. The offered request is the one on the highest level among eligible sources, whatever their polling positions, and `irq_level` reports that level.
- R3: Among eligible sources on the same level, the lowest index wins. Index (bit position in every 6-bit port) and polling order: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial port, 5 timer 2.
- R4: `irq_vector` equals 03h + 8 × winner index: 03h, 0Bh, 13h, 1Bh, 23h, 2Bh.
- R5: A source is eligible only when its `irq_flags` bit, its `en_mask` bit and `glb_en` are all 1. With no eligible source, `irq_valid` is 0.
- R6: `irq_valid` is 1 only when the winner's level is strictly greater than the highest set bit of `in_service`, or when `in_service` is 0000. `in_service` bit n stands for level n.
- R7: `vec_ack` while `irq_valid` is 1 sets `in_service[irq_level]` at the next clock edge.
- R8: `reti` clears the highest set bit of `in_service` at the next clock edge and leaves the lower bits as they were.
- R9: A one-cycle pulse on `tmr_ovf_set[k]` sets the timer k flag (index 1 for k=0, index 3 for k=1) at the next edge. Accepting that timer clears the flag. A set pulse in the same cycle as the acceptance wins, and the flag stays 1.
- R10: With `ext_edge_mode[k]`=1, a 0→1 change of `ext_pin[k]` sets the external k flag (index 0 or 2) at the next edge. The flag stays 1 after the pin falls, and accepting the source clears it.
- R11: With `ext_edge_mode[k]`=0, the external k flag equals `ext_pin[k]` in the same cycle. The serial (index 4) and timer 2 (index 5) flags equal `ser_req` and `t2_req`. Acceptance clears none of these flags.
- R12: `vec_ack` while `irq_valid` is 0 has no effect: `in_service` and the flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Global interrupt enable |
| en_mask | input | 6 | Per-source enables, index as in R3 |
| prio_lo | input | 6 | Low priority bit of each source |
| prio_hi | input | 6 | High priority bit of each source |
| ext_pin | input | 2 | External request inputs, active high |
| ext_edge_mode | input | 2 | 1 = edge-latched, 0 = follows the pin |
| tmr_ovf_set | input | 2 | Timer 0 and timer 1 overflow set pulses |
| ser_req | input | 1 | Serial port request (level) |
| t2_req | input | 1 | Timer 2 request (level) |
| vec_ack | input | 1 | CPU accepts the offered request |
| reti | input | 1 | CPU return-from-interrupt strobe |
| irq_valid | output | 1 | A request is offered to the CPU |
| irq_vector | output | 8 | Vector address of the winner |
| irq_level | output | 2 | Level of the winner |
| irq_flags | output | 6 | Current request flags, index as in R3 |
| in_service | output | 4 | In-service bit of each level |

## Verification
A table of priority settings and request sets covers the arbitration. All sources on level 0 show the pure polling order. Lifting a late source above an early one shows that level beats order. Equal high levels on the first and last source confirm that the order still decides inside a level. Masked and globally disabled patterns show that eligibility gates the choice. Directed sequences then cover nesting (a same-level request is held off, a higher one pre-empts, and a return restores the lower one), edge-latched against pin-following external inputs, and a timer set pulse that coincides with acceptance.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_W   = 3;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int NUM_EXT = 2;
  // bit positions of the source kinds; position is polling order
  localparam int IDX_EXT0 = 0;
  localparam int IDX_TMR0 = 1;
  localparam int IDX_EXT1 = 2;
  localparam int IDX_TMR1 = 3;
  localparam int IDX_SER  = 4;
  localparam int IDX_TMR2 = 5;
endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic [NUM_EXT-1:0] ext_edge_mode,
  input  logic [NUM_EXT-1:0] tmr_ovf_set,
  input  logic               ser_req,
  input  logic               t2_req,
  input  logic [NUM_SRC-1:0] clr_req,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_EXT-1:0] pin_q, pin_q_nxt;
  logic [NUM_EXT-1:0] edge_flag, edge_flag_nxt;
  logic [NUM_EXT-1:0] tmr_flag, tmr_flag_nxt;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_pair
    // external k sits at index 2k, timer k at 2k+1
    always_comb begin
      pin_q_nxt[k] = ext_pin[k];
      if (!ext_edge_mode[k])
        edge_flag_nxt[k] = 1'b0;
      else if (ext_pin[k] && !pin_q[k])
        edge_flag_nxt[k] = 1'b1;
      else if (clr_req[2*k])
        edge_flag_nxt[k] = 1'b0;
      else
        edge_flag_nxt[k] = edge_flag[k];

      if (tmr_ovf_set[k])
        tmr_flag_nxt[k] = 1'b1;
      else if (clr_req[2*k+1])
        tmr_flag_nxt[k] = 1'b0;
      else
        tmr_flag_nxt[k] = tmr_flag[k];
    end

    assign pend[2*k]   = ext_edge_mode[k] ? edge_flag[k] : ext_pin[k];
    assign pend[2*k+1] = tmr_flag[k];
  end

  assign pend[IDX_SER]  = ser_req;
  assign pend[IDX_TMR2] = t2_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= '0;
      edge_flag <= '0;
      tmr_flag  <= '0;
    end else begin
      pin_q     <= pin_q_nxt;
      edge_flag <= edge_flag_nxt;
      tmr_flag  <= tmr_flag_nxt;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic [NUM_LVL-1:0] in_service,
  output logic               win_valid,
  output logic [SRC_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  logic [NUM_SRC-1:0] elig;
  logic               found;
  logic               busy;
  logic [LVL_W-1:0]   busy_lvl;

  assign elig = pend & en_mask & {NUM_SRC{glb_en}};

  // search levels high to low, sources in polling order
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (!found && elig[s] && ({prio_hi[s], prio_lo[s]} == LVL_W'(l))) begin
          found   = 1'b1;
          win_idx = SRC_W'(s);
          win_lvl = LVL_W'(l);
        end
      end
    end
  end

  always_comb begin
    busy     = 1'b0;
    busy_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (in_service[l]) begin
        busy     = 1'b1;
        busy_lvl = LVL_W'(l);
      end
    end
  end

  assign win_valid = found && (!busy || (win_lvl > busy_lvl));
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] in_service
);
  logic [NUM_LVL-1:0] is_q, is_nxt;
  logic [NUM_LVL-1:0] pop_mask;
  logic [NUM_LVL-1:0] push_mask;

  always_comb begin
    pop_mask = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (is_q[l]) pop_mask = NUM_LVL'(1) << l;
    push_mask = push ? (NUM_LVL'(1) << push_lvl) : '0;
    is_nxt    = (is_q & ~(pop ? pop_mask : '0)) | push_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) is_q <= '0;
    else        is_q <= is_nxt;
  end

  assign in_service = is_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic [5:0]         en_mask,
  input  logic [5:0]         prio_lo,
  input  logic [5:0]         prio_hi,
  input  logic [1:0]         ext_pin,
  input  logic [1:0]         ext_edge_mode,
  input  logic [1:0]         tmr_ovf_set,
  input  logic               ser_req,
  input  logic               t2_req,
  input  logic               vec_ack,
  input  logic               reti,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [1:0]         irq_level,
  output logic [5:0]         irq_flags,
  output logic [3:0]         in_service
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [SRC_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               accept;
  logic [NUM_SRC-1:0] clr_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign accept  = vec_ack && irq_valid;
  assign clr_req = accept ? (NUM_SRC'(1) << win_idx) : '0;

  irq_flag_unit u_flags (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ext_pin       (ext_pin),
    .ext_edge_mode (ext_edge_mode),
    .tmr_ovf_set   (tmr_ovf_set),
    .ser_req       (ser_req),
    .t2_req        (t2_req),
    .clr_req       (clr_req),
    .pend          (irq_flags)
  );

  irq_arbiter u_arb (
    .pend       (irq_flags),
    .en_mask    (en_mask),
    .glb_en     (glb_en),
    .prio_lo    (prio_lo),
    .prio_hi    (prio_hi),
    .in_service (in_service),
    .win_valid  (irq_valid),
    .win_idx    (win_idx),
    .win_lvl    (win_lvl)
  );

  irq_inservice u_isr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (accept),
    .push_lvl   (win_lvl),
    .pop        (reti),
    .in_service (in_service)
  );

  assign irq_level  = win_lvl;
  assign irq_vector = VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx));
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic [5:0] en_mask,
  input logic       vec_ack,
  input logic       reti,
  input logic [1:0] tmr_ovf_set,
  input logic       irq_valid,
  input logic [7:0] irq_vector,
  input logic [1:0] irq_level,
  input logic [5:0] irq_flags,
  input logic [3:0] in_service
);
  AST_VALID_NEEDS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (glb_en && ((irq_flags & en_mask) != 6'd0))); // R5
  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((irq_vector[2:0] == 3'd3) && (irq_vector <= 8'h2B))); // R4
  AST_ONLY_HIGHER_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((in_service >> irq_level) == 4'd0)); // R6
  AST_ACCEPT_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq_valid) |=> in_service[$past(irq_level)]); // R7
  AST_RETURN_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(vec_ack && irq_valid) && (in_service != 4'd0))
      |=> ($countones(in_service) == $countones($past(in_service)) - 1)); // R8
  AST_TMR0_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq_valid && (irq_vector == 8'h0B) && !tmr_ovf_set[0])
      |=> !irq_flags[1]); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/100ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en;
  logic [5:0] en_mask, prio_lo, prio_hi;
  logic [1:0] ext_pin, ext_edge_mode, tmr_ovf_set;
  logic       ser_req, t2_req, vec_ack, reti;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic [1:0] irq_level;
  logic [5:0] irq_flags;
  logic [3:0] in_service;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (.*);

  typedef struct packed {
    logic [5:0] en; logic glb; logic [5:0] lo; logic [5:0] hi;
    logic [1:0] pins; logic ser; logic t2;
    logic ev; logic [7:0] evec; logic [1:0] elvl;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{6'h3f, 1'b1, 6'h00, 6'h00, 2'b11, 1'b1, 1'b1, 1'b1, 8'h03, 2'd0},
    '{6'h3f, 1'b1, 6'h00, 6'h00, 2'b00, 1'b1, 1'b1, 1'b1, 8'h23, 2'd0},
    '{6'h3f, 1'b1, 6'h20, 6'h00, 2'b11, 1'b1, 1'b1, 1'b1, 8'h2B, 2'd1},
    '{6'h3f, 1'b1, 6'h20, 6'h10, 2'b11, 1'b1, 1'b1, 1'b1, 8'h23, 2'd2},
    '{6'h3f, 1'b1, 6'h04, 6'h04, 2'b11, 1'b1, 1'b1, 1'b1, 8'h13, 2'd3},
    '{6'h3f, 1'b0, 6'h00, 6'h00, 2'b11, 1'b1, 1'b1, 1'b0, 8'h00, 2'd0},
    '{6'h3e, 1'b1, 6'h00, 6'h00, 2'b11, 1'b1, 1'b1, 1'b1, 8'h13, 2'd0},
    '{6'h00, 1'b1, 6'h00, 6'h00, 2'b11, 1'b1, 1'b1, 1'b0, 8'h00, 2'd0},
    '{6'h3f, 1'b1, 6'h21, 6'h21, 2'b11, 1'b1, 1'b1, 1'b1, 8'h03, 2'd3},
    '{6'h3f, 1'b1, 6'h00, 6'h00, 2'b00, 1'b0, 1'b1, 1'b1, 8'h2B, 2'd0},
    '{6'h3f, 1'b1, 6'h00, 6'h00, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0},
    '{6'h3f, 1'b1, 6'h04, 6'h01, 2'b11, 1'b1, 1'b1, 1'b1, 8'h03, 2'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change at the falling edge; one call moves past one rising edge
  task automatic step();
    @(negedge clk);
    #0.2;
  endtask

  task automatic settle();
    #0.2;
  endtask

  task automatic pulse_ack();
    vec_ack = 1'b1; step(); vec_ack = 1'b0; settle();
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(); reti = 1'b0; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; en_mask = 6'h3f; prio_lo = '0; prio_hi = '0;
    ext_pin = '0; ext_edge_mode = '0; tmr_ovf_set = '0;
    ser_req = 0; t2_req = 0; vec_ack = 0; reti = 0;
    repeat (3) step();
    chk("R1 valid in reset", irq_valid, 0);
    chk("R1 in_service in reset", in_service, 4'b0000);
    chk("R1 flags in reset", irq_flags, 6'h00);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 flags after release", irq_flags, 6'h00);
    chk("R1 in_service after release", in_service, 4'b0000);

    // arbitration table, nothing in service
    for (int i = 0; i < NROW; i++) begin
      en_mask = TBL[i].en; glb_en = TBL[i].glb; prio_lo = TBL[i].lo; prio_hi = TBL[i].hi;
      ext_pin = TBL[i].pins; ser_req = TBL[i].ser; t2_req = TBL[i].t2;
      settle();
      chk($sformatf("R5 R6 table row %0d valid", i), irq_valid, TBL[i].ev);
      if (TBL[i].ev) begin
        chk($sformatf("R3 R4 table row %0d vector", i), irq_vector, TBL[i].evec);
        chk($sformatf("R2 table row %0d level", i), irq_level, TBL[i].elvl);
      end
    end
    en_mask = 6'h3f; glb_en = 1; prio_lo = 0; prio_hi = 0; ext_pin = 0; ser_req = 0; t2_req = 0;
    step();

    // timer 0 flag, acceptance and nesting
    tmr_ovf_set = 2'b01; step(); tmr_ovf_set = 2'b00; settle();
    chk("R9 timer0 flag set", irq_flags[1], 1);
    chk("R4 timer0 vector", irq_vector, 8'h0B);
    pulse_ack();
    chk("R9 timer0 flag cleared", irq_flags[1], 0);
    chk("R7 level0 in service", in_service, 4'b0001);
    ser_req = 1; settle();
    chk("R6 same level held off", irq_valid, 0);
    prio_lo = 6'h10; settle();
    chk("R6 higher level offered", irq_valid, 1);
    chk("R2 serial level", irq_level, 2'd1);
    pulse_ack();
    chk("R7 nested in service", in_service, 4'b0011);
    chk("R11 serial flag kept", irq_flags[4], 1);
    chk("R6 nothing above level1", irq_valid, 0);
    pulse_reti();
    chk("R8 pop highest", in_service, 4'b0001);
    chk("R8 serial offered again", irq_valid, 1);
    pulse_reti();
    chk("R8 pop last", in_service, 4'b0000);
    ser_req = 0; prio_lo = 0; settle();

    // external 0 edge-latched
    ext_edge_mode = 2'b01; ext_pin = 2'b01; step();
    chk("R10 edge flag set", irq_flags[0], 1);
    chk("R4 ext0 vector", irq_vector, 8'h03);
    ext_pin = 2'b00; step();
    chk("R10 flag held after pin fall", irq_flags[0], 1);
    pulse_ack();
    chk("R10 flag cleared on accept", irq_flags[0], 0);
    pulse_reti();

    // external 1 pin-following
    ext_edge_mode = 2'b00; ext_pin = 2'b10; settle();
    chk("R11 level flag follows pin", irq_flags[2], 1);
    chk("R4 ext1 vector", irq_vector, 8'h13);
    pulse_ack();
    chk("R11 level flag not cleared", irq_flags[2], 1);
    chk("R7 ext1 in service", in_service, 4'b0001);
    ext_pin = 2'b00; settle();
    chk("R11 level flag drops with pin", irq_flags[2], 0);
    pulse_reti();

    // acknowledge with nothing offered
    settle();
    chk("R12 nothing offered", irq_valid, 0);
    pulse_ack();
    chk("R12 in_service unchanged", in_service, 4'b0000);
    chk("R12 flags unchanged", irq_flags, 6'h00);

    // timer 1: set pulse coincides with acceptance
    tmr_ovf_set = 2'b10; step(); tmr_ovf_set = 2'b00; settle();
    chk("R9 timer1 flag set", irq_flags[3], 1);
    vec_ack = 1; tmr_ovf_set = 2'b10; step(); vec_ack = 0; tmr_ovf_set = 2'b00; settle();
    chk("R9 set wins over clear", irq_flags[3], 1);
    chk("R7 timer1 in service", in_service, 4'b0001);
    pulse_reti();
    pulse_ack();
    chk("R9 timer1 flag cleared", irq_flags[3], 0);
    pulse_reti();
    chk("R8 all retired", in_service, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule